// File: doc/BRIEF.md
# SIMD Dual-Issue Pairing Checker

This block sits at the issue point of an in-order core with two execution slots and decides, one instruction at a time, whether a decoded SIMD instruction may go out in the same cycle as the one before it. A SIMD instruction that finds the waiting slot empty is held there. The next arrival either joins it as a pair or forces it out alone. The block reports how many issue groups left, how many cycles they were charged and how many address-generation stalls were added. It also keeps the set of registers written by the most recent issue group, which is what later address-generation checks compare against.

Opcode decoding and register-mask extraction happen upstream. Each arrival carries a class code, destination, source and address register masks, two flags for implicit stack-pointer use, a base cycle count and prefix information. Start-of-block and end-of-block strobes mark the edges of a translated code block. Every result appears on the outputs one clock after the arrival or strobe that caused it.

Top module: `simd_pair_issue`

## Requirements
- R1: Class codes are 0 scalar, 1 any-pipe, 2 multiply, 3 shift/pack and 4 3D-float; codes 1 to 4 are SIMD. A scalar arrival never pairs. It first sends any held instruction out alone, then issues alone itself.
- R2: A held multiply and an arriving multiply never pair, and neither does a held shift/pack with an arriving shift/pack. A multiply may pair with a shift/pack.
- R3: Pairing is refused when the arrival's source mask shares any bit with the held instruction's destination mask.
- R4: An instruction's decode cycles are its prefix count minus one if the two-byte escape prefix is among them (in_esc=1). Pairing needs residual delay + held decode cycles + arriving decode cycles <= 0. The residual delay is 0 after a block start and 1 - (base + stall) after each issue group.
- R5: A pair is one issue group charged the larger of the two base counts plus its stall; its decode cycles are the sum of both.
- R6: A SIMD arrival that finds the slot empty is held, and that step reports 0 groups and 0 cycles.
- R7: An arrival that cannot pair sends the held instruction out alone first. The arrival is then held if it is SIMD, and otherwise issued alone.
- R8: A group is charged base + stall + max(0, residual delay + its decode cycles), and res_cycles is the sum over the groups of one step.
- R9: A group gets one stall cycle when its address mask (the union for a pair) overlaps the modified-register record.
- R10: Implicit stack-pointer use (in_addr_sp_impl) stalls only if the record holds the stack-pointer bit (bit SP_IDX) written explicitly (in_dst_sp_impl=0 for that write).
- R11: After a group issues, the record equals its destination mask: the union of both for a pair, and a single instruction's own mask otherwise.
- R12: blk_end sends the held instruction out alone, and an arriving SIMD instruction in that cycle issues alone rather than being held.
- R13: blk_start empties the slot and clears the residual delay and the record, ignores in_valid and blk_end in that cycle, and produces no result.
- R14: After reset the slot is empty, res_valid is 0 and every result and mod_regs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Start of a code block |
| blk_end | input | 1 | End of a code block |
| in_valid | input | 1 | An instruction arrives |
| in_cls | input | 3 | Class code |
| in_dst | input | NREG | Destination register mask |
| in_src | input | NREG | Source register mask |
| in_addr | input | NREG | Address register mask |
| in_addr_sp_impl | input | 1 | Uses the stack pointer implicitly for addressing |
| in_dst_sp_impl | input | 1 | Its stack-pointer write is implicit |
| in_cycles | input | CW | Base cycle count |
| in_pfx | input | PW | Number of prefix bytes |
| in_esc | input | 1 | One of the prefixes is the two-byte escape |
| res_valid | output | 1 | A step was processed last cycle |
| res_paired | output | 1 | The step issued a pair |
| res_issues | output | 2 | Issue groups sent in the step |
| res_cycles | output | OW | Cycles charged in the step |
| res_stalls | output | 2 | Address-generation stalls in the step |
| mod_regs | output | NREG | Modified-register record |

## Verification
Within one step the block can flush a held instruction and then issue the arriving scalar instruction. In that case the second group's stall and decode charge must be judged against the record and residual delay that the flush has just produced. The bench provokes this by parking a SIMD instruction whose destination is the scalar arrival's address register, and by following a short-cycle flush with a prefixed scalar. Both reported counts are compared with a sequential reference model. Pairing and end-of-block flushing also meet when blk_end coincides with a pairable arrival, and random streams with sparse strobes exercise that combination.

// File: rtl/simd_pair_pkg.sv
package simd_pair_pkg;

    typedef enum logic [2:0] {
        CLS_SCALAR = 3'd0,
        CLS_ANY    = 3'd1,
        CLS_MUL    = 3'd2,
        CLS_SHIFT  = 3'd3,
        CLS_F3D    = 3'd4
    } simd_cls_e;

    function automatic logic is_simd(input logic [2:0] c);
        return (c == CLS_ANY) || (c == CLS_MUL) || (c == CLS_SHIFT) || (c == CLS_F3D);
    endfunction

endpackage

// File: rtl/simd_pair_rules.sv
module simd_pair_rules
    import simd_pair_pkg::*;
#(
    parameter int NREG = 8,
    parameter int PDW  = 4,
    parameter int DDW  = 12
) (
    input  logic [2:0]            held_cls,
    input  logic [NREG-1:0]       held_dst,
    input  logic [PDW-1:0]        held_pd,
    input  logic [2:0]            new_cls,
    input  logic [NREG-1:0]       new_src,
    input  logic [PDW-1:0]        new_pd,
    input  logic signed [DDW-1:0] dd,
    output logic                  ok
);
    logic signed [DDW-1:0] dsum;
    logic unit_clash;
    logic reg_clash;
    logic decode_late;

    always_comb begin
        dsum = dd + signed'(DDW'(held_pd)) + signed'(DDW'(new_pd));
        unit_clash = ((held_cls == CLS_MUL) && (new_cls == CLS_MUL)) ||
                     ((held_cls == CLS_SHIFT) && (new_cls == CLS_SHIFT));
        reg_clash = |(held_dst & new_src);
        decode_late = !(dsum[DDW-1] || (dsum == '0));
        ok = is_simd(new_cls) && !unit_clash && !reg_clash && !decode_late;
    end
endmodule

// File: rtl/simd_agi_detect.sv
module simd_agi_detect #(
    parameter int NREG   = 8,
    parameter int SP_IDX = 4
) (
    input  logic [NREG-1:0] addr,
    input  logic            addr_sp_impl,
    input  logic [NREG-1:0] mods,
    input  logic            mod_sp_impl,
    output logic            stall
);
    always_comb begin
        stall = (|(addr & mods)) || (addr_sp_impl && mods[SP_IDX] && !mod_sp_impl);
    end
endmodule

// File: rtl/simd_issue_cost.sv
module simd_issue_cost #(
    parameter int CW  = 6,
    parameter int PDW = 4,
    parameter int DDW = 12,
    parameter int OW  = 9
) (
    input  logic [CW-1:0]         cyc,
    input  logic                  stall,
    input  logic [PDW-1:0]        pd,
    input  logic signed [DDW-1:0] dd,
    output logic [OW-1:0]         charge,
    output logic signed [DDW-1:0] dd_next
);
    localparam logic signed [DDW-1:0] ONE = 1;

    logic signed [DDW-1:0] base;
    logic signed [DDW-1:0] extra;
    logic signed [DDW-1:0] extra_c;
    logic signed [DDW-1:0] total;

    always_comb begin
        base    = signed'(DDW'(cyc)) + signed'(DDW'(stall));
        extra   = dd + signed'(DDW'(pd));
        extra_c = extra[DDW-1] ? '0 : extra;
        total   = base + extra_c;
        charge  = OW'(total);
        dd_next = ONE - base;
    end
endmodule

// File: rtl/simd_pair_issue.sv
module simd_pair_issue
    import simd_pair_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int SP_IDX = 4,
    parameter int CW     = 6,
    parameter int PW     = 3,
    localparam int OW    = ((CW > PW) ? CW : PW) + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_start,
    input  logic            blk_end,
    input  logic            in_valid,
    input  logic [2:0]      in_cls,
    input  logic [NREG-1:0] in_dst,
    input  logic [NREG-1:0] in_src,
    input  logic [NREG-1:0] in_addr,
    input  logic            in_addr_sp_impl,
    input  logic            in_dst_sp_impl,
    input  logic [CW-1:0]   in_cycles,
    input  logic [PW-1:0]   in_pfx,
    input  logic            in_esc,
    output logic            res_valid,
    output logic            res_paired,
    output logic [1:0]      res_issues,
    output logic [OW-1:0]   res_cycles,
    output logic [1:0]      res_stalls,
    output logic [NREG-1:0] mod_regs
);
    localparam int PDW = PW + 1;
    localparam int DDW = CW + PW + 3;
    localparam int NGRP = 2;

    typedef struct packed {
        logic                  slot_v;
        logic [2:0]            slot_cls;
        logic [NREG-1:0]       slot_dst;
        logic [NREG-1:0]       slot_addr;
        logic                  slot_asp;
        logic                  slot_dsp;
        logic [CW-1:0]         slot_cyc;
        logic [PDW-1:0]        slot_pd;
        logic signed [DDW-1:0] dd;
        logic [NREG-1:0]       mods;
        logic                  mod_spi;
        logic                  rv;
        logic                  rp;
        logic [1:0]            ri;
        logic [OW-1:0]         rc;
        logic [1:0]            rs;
    } st_t;

    st_t q, d;

    logic [PDW-1:0] in_pd;
    logic arrive, step, pair_ok, pair, b_park;
    logic [CW-1:0] cyc_max;

    logic                  g_act   [NGRP];
    logic [NREG-1:0]       g_addr  [NGRP];
    logic [NREG-1:0]       g_dst   [NGRP];
    logic [NREG-1:0]       g_mod   [NGRP];
    logic                  g_asp   [NGRP];
    logic                  g_dsp   [NGRP];
    logic                  g_spi   [NGRP];
    logic [CW-1:0]         g_cyc   [NGRP];
    logic [PDW-1:0]        g_pd    [NGRP];
    logic signed [DDW-1:0] g_dd    [NGRP];
    logic signed [DDW-1:0] g_ddn   [NGRP];
    logic [OW-1:0]         g_chg   [NGRP];
    logic                  g_stall [NGRP];

    assign in_pd   = PDW'(in_pfx) - PDW'(in_esc);
    assign arrive  = in_valid && !blk_start;
    assign step    = (in_valid || blk_end) && !blk_start;
    assign pair    = q.slot_v && arrive && pair_ok;
    assign b_park  = arrive && !pair && is_simd(in_cls) && !blk_end;
    assign cyc_max = (q.slot_cyc > in_cycles) ? q.slot_cyc : in_cycles;

    simd_pair_rules #(.NREG(NREG), .PDW(PDW), .DDW(DDW)) u_rules (
        .held_cls (q.slot_cls),
        .held_dst (q.slot_dst),
        .held_pd  (q.slot_pd),
        .new_cls  (in_cls),
        .new_src  (in_src),
        .new_pd   (in_pd),
        .dd       (q.dd),
        .ok       (pair_ok)
    );

    // Group 0: the held instruction, alone or joined by the arrival.
    assign g_act[0]  = q.slot_v && step;
    assign g_addr[0] = pair ? (q.slot_addr | in_addr) : q.slot_addr;
    assign g_dst[0]  = pair ? (q.slot_dst | in_dst) : q.slot_dst;
    assign g_asp[0]  = pair ? (q.slot_asp | in_addr_sp_impl) : q.slot_asp;
    assign g_dsp[0]  = pair ? (q.slot_dsp | in_dst_sp_impl) : q.slot_dsp;
    assign g_cyc[0]  = pair ? cyc_max : q.slot_cyc;
    assign g_pd[0]   = pair ? (q.slot_pd + in_pd) : q.slot_pd;
    assign g_mod[0]  = q.mods;
    assign g_spi[0]  = q.mod_spi;
    assign g_dd[0]   = q.dd;

    // Group 1: the arrival issued alone, after group 0 has updated state.
    assign g_act[1]  = arrive && !pair && !b_park;
    assign g_addr[1] = in_addr;
    assign g_dst[1]  = in_dst;
    assign g_asp[1]  = in_addr_sp_impl;
    assign g_dsp[1]  = in_dst_sp_impl;
    assign g_cyc[1]  = in_cycles;
    assign g_pd[1]   = in_pd;
    assign g_mod[1]  = g_act[0] ? g_dst[0] : q.mods;
    assign g_spi[1]  = g_act[0] ? g_dsp[0] : q.mod_spi;
    assign g_dd[1]   = g_act[0] ? g_ddn[0] : q.dd;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        simd_agi_detect #(.NREG(NREG), .SP_IDX(SP_IDX)) u_agi (
            .addr         (g_addr[g]),
            .addr_sp_impl (g_asp[g]),
            .mods         (g_mod[g]),
            .mod_sp_impl  (g_spi[g]),
            .stall        (g_stall[g])
        );
        simd_issue_cost #(.CW(CW), .PDW(PDW), .DDW(DDW), .OW(OW)) u_cost (
            .cyc     (g_cyc[g]),
            .stall   (g_stall[g]),
            .pd      (g_pd[g]),
            .dd      (g_dd[g]),
            .charge  (g_chg[g]),
            .dd_next (g_ddn[g])
        );
    end

    always_comb begin
        d    = q;
        d.rv = step;
        d.rp = pair;
        d.ri = {1'b0, g_act[0]} + {1'b0, g_act[1]};
        d.rc = (g_act[0] ? g_chg[0] : '0) + (g_act[1] ? g_chg[1] : '0);
        d.rs = {1'b0, g_act[0] && g_stall[0]} + {1'b0, g_act[1] && g_stall[1]};
        if (g_act[1]) begin
            d.dd      = g_ddn[1];
            d.mods    = g_dst[1];
            d.mod_spi = g_dsp[1];
        end else if (g_act[0]) begin
            d.dd      = g_ddn[0];
            d.mods    = g_dst[0];
            d.mod_spi = g_dsp[0];
        end
        if (g_act[0]) begin
            d.slot_v = 1'b0;
        end
        if (b_park) begin
            d.slot_v    = 1'b1;
            d.slot_cls  = in_cls;
            d.slot_dst  = in_dst;
            d.slot_addr = in_addr;
            d.slot_asp  = in_addr_sp_impl;
            d.slot_dsp  = in_dst_sp_impl;
            d.slot_cyc  = in_cycles;
            d.slot_pd   = in_pd;
        end
        if (blk_start) begin
            d.slot_v  = 1'b0;
            d.dd      = '0;
            d.mods    = '0;
            d.mod_spi = 1'b0;
            d.rv      = 1'b0;
            d.rp      = 1'b0;
            d.ri      = '0;
            d.rc      = '0;
            d.rs      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign res_valid  = q.rv;
    assign res_paired = q.rp;
    assign res_issues = q.ri;
    assign res_cycles = q.rc;
    assign res_stalls = q.rs;
    assign mod_regs   = q.mods;
endmodule

// File: rtl/simd_pair_chk.sv
module simd_pair_chk
    import simd_pair_pkg::*;
#(
    parameter int NREG = 8,
    parameter int OW   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            blk_start,
    input logic            blk_end,
    input logic            in_valid,
    input logic [2:0]      in_cls,
    input logic            in_esc,
    input logic [2:0]      in_pfx_nz,
    input logic            res_valid,
    input logic            res_paired,
    input logic [1:0]      res_issues,
    input logic [OW-1:0]   res_cycles,
    input logic [1:0]      res_stalls,
    input logic [NREG-1:0] mod_regs
);
    // R13
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> (!res_valid && (mod_regs == '0)));

    // R1
    scalar_never_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !blk_start && (in_cls == CLS_SCALAR)) |=> (!res_paired && (res_issues != 2'd0)));

    // R5
    pair_one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_paired |-> (res_issues == 2'd1));

    // R9
    stall_per_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_stalls <= res_issues);

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_paired && (res_issues == 2'd0) && (res_cycles == '0)));

    // R12
    end_then_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !blk_start) ##1 (in_valid && is_simd(in_cls) && !blk_start && !blk_end)
        |=> (res_issues == 2'd0));

    // R4
    escape_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_esc) |-> (in_pfx_nz != 3'd0));
endmodule

bind simd_pair_issue simd_pair_chk #(.NREG(NREG), .OW(OW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_start  (blk_start),
    .blk_end    (blk_end),
    .in_valid   (in_valid),
    .in_cls     (in_cls),
    .in_esc     (in_esc),
    .in_pfx_nz  (3'(in_pfx)),
    .res_valid  (res_valid),
    .res_paired (res_paired),
    .res_issues (res_issues),
    .res_cycles (res_cycles),
    .res_stalls (res_stalls),
    .mod_regs   (mod_regs)
);

// File: tb/test_simd_pair_issue.sv
`timescale 1ns/1ps
module test_simd_pair_issue;
    localparam int NREG = 8;
    localparam int SPI  = 4;
    localparam int CW   = 6;
    localparam int PW   = 3;
    localparam int OW   = 9;
    localparam int LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_start = 0, blk_end = 0, in_valid = 0;
    logic [2:0] in_cls = 0;
    logic [NREG-1:0] in_dst = 0, in_src = 0, in_addr = 0;
    logic in_asp = 0, in_dsp = 0;
    logic [CW-1:0] in_cycles = 0;
    logic [PW-1:0] in_pfx = 0;
    logic in_esc = 0;
    logic res_valid, res_paired;
    logic [1:0] res_issues, res_stalls;
    logic [OW-1:0] res_cycles;
    logic [NREG-1:0] mod_regs;

    always #2.5 clk = ~clk;

    simd_pair_issue #(.NREG(NREG), .SP_IDX(SPI), .CW(CW), .PW(PW)) i_simd_pair_issue (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_end(blk_end),
        .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst), .in_src(in_src),
        .in_addr(in_addr), .in_addr_sp_impl(in_asp), .in_dst_sp_impl(in_dsp),
        .in_cycles(in_cycles), .in_pfx(in_pfx), .in_esc(in_esc),
        .res_valid(res_valid), .res_paired(res_paired), .res_issues(res_issues),
        .res_cycles(res_cycles), .res_stalls(res_stalls), .mod_regs(mod_regs)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state
    bit m_sv; int m_scls; logic [7:0] m_sdst, m_saddr; bit m_sasp, m_sdsp; int m_scyc, m_spd;
    int m_dd; logic [7:0] m_mod; bit m_spi;
    int e_v, e_p, e_i, e_c, e_s;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic m_issue(input logic [7:0] addr, input bit asp, input logic [7:0] dst,
                           input bit dsp, input int cyc, input int pd);
        int st, base, ex;
        st = (((addr & m_mod) != 0) || (asp && m_mod[SPI] && !m_spi)) ? 1 : 0;
        base = cyc + st;
        ex = m_dd + pd;
        if (ex < 0) ex = 0;
        e_c += base + ex;
        e_s += st;
        e_i += 1;
        m_dd = 1 - base;
        m_mod = dst;
        m_spi = dsp;
    endtask

    task automatic m_step();
        int pd; bit simd, pr;
        e_v = 0; e_p = 0; e_i = 0; e_c = 0; e_s = 0;
        if (blk_start) begin
            m_sv = 0; m_dd = 0; m_mod = 0; m_spi = 0;
            return;
        end
        if (!(in_valid || blk_end)) return;
        e_v = 1;
        pd = int'(in_pfx) - int'(in_esc);
        simd = (in_cls >= 1) && (in_cls <= 4);
        pr = m_sv && in_valid && simd && !(m_scls == 2 && in_cls == 2) &&
             !(m_scls == 3 && in_cls == 3) && ((m_sdst & in_src) == 0) &&
             (m_dd + m_spd + pd <= 0);
        if (pr) begin
            e_p = 1;
            m_issue(m_saddr | in_addr, m_sasp | in_asp, m_sdst | in_dst, m_sdsp | in_dsp,
                    (m_scyc > int'(in_cycles)) ? m_scyc : int'(in_cycles), m_spd + pd);
            m_sv = 0;
        end else begin
            if (m_sv) begin
                m_issue(m_saddr, m_sasp, m_sdst, m_sdsp, m_scyc, m_spd);
                m_sv = 0;
            end
            if (in_valid) begin
                if (simd && !blk_end) begin
                    m_sv = 1; m_scls = in_cls; m_sdst = in_dst; m_saddr = in_addr;
                    m_sasp = in_asp; m_sdsp = in_dsp; m_scyc = in_cycles; m_spd = pd;
                end else begin
                    m_issue(in_addr, in_asp, in_dst, in_dsp, in_cycles, pd);
                end
            end
        end
    endtask

    task automatic drive(input bit st, input bit en, input bit v, input int cls,
                         input logic [7:0] dst, input logic [7:0] src, input logic [7:0] addr,
                         input bit asp, input bit dsp, input int cyc, input int pfx, input bit esc);
        blk_start = st; blk_end = en; in_valid = v; in_cls = 3'(cls);
        in_dst = dst; in_src = src; in_addr = addr; in_asp = asp; in_dsp = dsp;
        in_cycles = CW'(cyc); in_pfx = PW'(pfx); in_esc = esc;
        m_step();
        @(posedge clk);
        @(negedge clk);
        blk_start = 0; blk_end = 0; in_valid = 0;
    endtask

    task automatic check_model(input string tag);
        check({tag, " valid"}, int'(res_valid), e_v);
        check({tag, " paired"}, int'(res_paired), e_p);
        check({tag, " issues"}, int'(res_issues), e_i);
        check({tag, " cycles"}, int'(res_cycles), e_c);
        check({tag, " stalls"}, int'(res_stalls), e_s);
        check({tag, " record"}, int'(mod_regs), int'(m_mod));
    endtask

    typedef struct packed {
        logic st; logic en; logic v; logic [2:0] cls;
        logic [7:0] dst; logic [7:0] src; logic [7:0] addr;
        logic [5:0] cyc; logic [2:0] pfx; logic esc;
        logic ep; logic [1:0] ei; logic [8:0] ec; logic [1:0] es;
    } vec_t;

    localparam vec_t TBL [0:10] = '{
        '{1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 6'd0, 3'd0, 1'b0, 1'b0, 2'd0, 9'd0, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd1, 8'h01, 8'h00, 8'h00, 6'd1, 3'd0, 1'b0, 1'b0, 2'd0, 9'd0, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd2, 8'h02, 8'h04, 8'h00, 6'd2, 3'd0, 1'b0, 1'b1, 2'd1, 9'd2, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd2, 8'h04, 8'h00, 8'h00, 6'd1, 3'd0, 1'b0, 1'b0, 2'd0, 9'd0, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd2, 8'h08, 8'h00, 8'h00, 6'd1, 3'd0, 1'b0, 1'b0, 2'd1, 9'd1, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd3, 8'h10, 8'h08, 8'h00, 6'd1, 3'd0, 1'b0, 1'b0, 2'd1, 9'd1, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd0, 8'h01, 8'h00, 8'h08, 6'd3, 3'd0, 1'b0, 1'b0, 2'd2, 9'd4, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd0, 8'h02, 8'h00, 8'h01, 6'd2, 3'd0, 1'b0, 1'b0, 2'd1, 9'd3, 2'd1},
        '{1'b0, 1'b0, 1'b1, 3'd1, 8'h04, 8'h00, 8'h00, 6'd1, 3'd2, 1'b1, 1'b0, 2'd0, 9'd0, 2'd0},
        '{1'b0, 1'b0, 1'b1, 3'd1, 8'h08, 8'h00, 8'h00, 6'd1, 3'd2, 1'b0, 1'b0, 2'd1, 9'd1, 2'd0},
        '{1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 6'd0, 3'd0, 1'b0, 1'b0, 2'd1, 9'd3, 2'd0}
    };

    initial begin
        #(LIMIT * 5.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_sv = 0; m_dd = 0; m_mod = 0; m_spi = 0; m_scls = 0; m_sdst = 0; m_saddr = 0;
        m_sasp = 0; m_sdsp = 0; m_scyc = 0; m_spd = 0;
        repeat (3) @(negedge clk);
        // R14: reset state
        check("R14 valid after reset", int'(res_valid), 0);
        check("R14 record after reset", int'(mod_regs), 0);
        check("R14 cycles after reset", int'(res_cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: R6 park, R5 pair, R2 mul clash, R3 reg clash, R1 scalar, R9 stall, R4 prefixes, R12 end
        for (int k = 0; k <= 10; k++) begin
            drive(TBL[k].st, TBL[k].en, TBL[k].v, int'(TBL[k].cls), TBL[k].dst, TBL[k].src,
                  TBL[k].addr, 1'b0, 1'b0, int'(TBL[k].cyc), int'(TBL[k].pfx), TBL[k].esc);
            check($sformatf("R7 table %0d paired", k), int'(res_paired), int'(TBL[k].ep));
            check($sformatf("R8 table %0d issues", k), int'(res_issues), int'(TBL[k].ei));
            check($sformatf("R8 table %0d cycles", k), int'(res_cycles), int'(TBL[k].ec));
            check($sformatf("R9 table %0d stalls", k), int'(res_stalls), int'(TBL[k].es));
            check_model($sformatf("R5 table %0d model", k));
        end

        // R2: multiply pairs with shift/pack
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 2, 8'h01, 8'h00, 8'h00, 0, 0, 2, 0, 0);
        drive(0, 0, 1, 3, 8'h02, 8'h00, 8'h00, 0, 0, 3, 0, 0);
        check("R2 mul with shift pairs", int'(res_paired), 1);
        check("R5 pair charge max", int'(res_cycles), 3);
        check("R11 pair record union", int'(mod_regs), 8'h03);

        // R4: escape prefix is free; a plain prefix blocks
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 1, 8'h01, 8'h00, 8'h00, 0, 0, 1, 1, 1);
        drive(0, 0, 1, 4, 8'h02, 8'h00, 8'h00, 0, 0, 1, 1, 1);
        check("R4 escape prefix free pairs", int'(res_paired), 1);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 1, 8'h01, 8'h00, 8'h00, 0, 0, 1, 0, 0);
        drive(0, 0, 1, 4, 8'h02, 8'h00, 8'h00, 0, 0, 1, 1, 0);
        check("R4 plain prefix blocks pair", int'(res_paired), 0);
        check_model("R4 model");

        // R10: implicit stack use vs implicit / explicit stack write
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 8'h10, 8'h00, 8'h00, 0, 1, 1, 0, 0);
        drive(0, 0, 1, 0, 8'h10, 8'h00, 8'h00, 1, 0, 1, 0, 0);
        check("R10 implicit after implicit no stall", int'(res_stalls), 0);
        drive(0, 0, 1, 0, 8'h01, 8'h00, 8'h00, 1, 0, 1, 0, 0);
        check("R10 implicit after explicit stalls", int'(res_stalls), 1);
        check_model("R10 model");

        // R1 / R7: flush then scalar in the same step, scalar sees flushed record
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 1, 8'h20, 8'h00, 8'h00, 0, 0, 1, 0, 0);
        drive(0, 0, 1, 0, 8'h01, 8'h00, 8'h20, 0, 0, 2, 1, 0);
        check("R7 flush and scalar issues", int'(res_issues), 2);
        check("R9 scalar stalls on flushed record", int'(res_stalls), 1);
        check_model("R1 model");

        // R13: start ignores arrival and clears slot
        drive(0, 0, 1, 1, 8'h01, 8'h00, 8'h00, 0, 0, 1, 0, 0);
        drive(1, 0, 1, 1, 8'h02, 8'h00, 8'h00, 0, 0, 1, 0, 0);
        check("R13 start no result", int'(res_valid), 0);
        check("R13 start clears record", int'(mod_regs), 0);
        drive(0, 0, 1, 1, 8'h04, 8'h00, 8'h00, 0, 0, 1, 0, 0);
        check("R13 slot empty after start", int'(res_issues), 0);

        // R12: end with arriving SIMD issues both alone
        drive(0, 1, 1, 2, 8'h08, 8'h04, 8'h00, 0, 0, 1, 0, 0);
        check("R12 end issues held and arrival", int'(res_issues), 2);
        check_model("R12 model");

        // Random streams against the reference model (R3 R8 R11)
        for (int k = 0; k < 600; k++) begin
            int pfx;
            pfx = $urandom % 4;
            drive(($urandom % 40) == 0, ($urandom % 10) == 0, ($urandom % 8) != 0,
                  $urandom % 5, 8'(1 << ($urandom % 8)),
                  (($urandom % 2) != 0) ? 8'(1 << ($urandom % 8)) : 8'h00,
                  (($urandom % 3) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00,
                  ($urandom % 4) == 0, ($urandom % 2) == 0, $urandom % 8, pfx,
                  (pfx != 0) && (($urandom % 2) != 0));
            check_model($sformatf("R8 random %0d", k));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule